// File: doc/BRIEF.md
# Packet-Alarm DMA Bridge FIFO

This block is a long-word FIFO that sits between a 32-bit host side, which a DMA engine serves, and a 16-bit device data side. In receive mode the device streams halfwords in. The block packs each pair into one long word, and the host drains the long words. In transmit mode the host fills long words, and the block streams them out to the device as halfwords. Halfword order is little-endian in both directions: bits [15:0] of a long word travel first and bits [31:16] second.

The DMA engine is paced by two request alarms. These alarms do not report single words. The receive alarm means at least one whole packet is ready for the host to read. The transmit alarm means the FIFO has room for at least one whole packet. The packet length is an input counted in long words. The block clamps it into the range 1 to the FIFO depth. The host side uses plain strobes with no back-pressure, because the alarms are meant to keep it in bounds. A host write into a full FIFO or a host read from an empty FIFO is dropped and sets a sticky error flag.

The device side uses valid/ready handshakes. A beat moves on a rising edge where valid and ready are both high. A source holds its data stable while valid is high and ready is low. The receive input lowers ready only when a low halfword is already held and the FIFO has no free word. The transmit output keeps valid high, with stable data, until the halfword is taken. A flush empties the FIFO, discards any half-assembled word and clears the error flag.

Top module: `pkt_alarm_fifo`

## Requirements
- R1: After reset the FIFO is empty, both alarms and the error flag are low, d_out_valid is low, and d_in_ready is high while dir_tx is 0 (receive mode).
- R2: rx_alarm is registered. On each edge it is set to 1 only when dir_tx is 0, flush is low, and the occupancy before that edge is at least the effective packet length. So it follows an occupancy change by one clock.
- R3: tx_alarm is registered. On each edge it is set to 1 only when dir_tx is 1, flush is low, and DEPTH minus the occupancy is at least the effective packet length.
- R4: The effective packet length is 1 when pkt_len is 0, DEPTH (16 by default) when pkt_len is above DEPTH, and pkt_len otherwise.
- R5: In receive mode the first accepted device halfword becomes bits [15:0] of a long word and the second becomes bits [31:16]. The word enters the FIFO on the second beat.
- R6: In transmit mode each long word leaves as bits [15:0] first and bits [31:16] second. While d_out_ready is low, d_out_valid stays high and d_out_data stays unchanged.
- R7: d_in_ready is low exactly when the block is in receive mode holding a low halfword and the FIFO is full. It is high in receive mode otherwise.
- R8: In transmit mode a host write while the FIFO holds DEPTH words is not stored and sets xfer_err. Occupancy never exceeds DEPTH.
- R9: In receive mode a host read while the FIFO is empty changes nothing in the FIFO and sets xfer_err.
- R10: A cycle with flush high leaves the FIFO empty, drops any held halfword, and clears xfer_err. Both alarms are low in the following cycle.
- R11: Long words leave the FIFO in the order they entered, in both directions. h_rd_data shows the oldest word whenever the FIFO is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empty the FIFO, drop partial word, clear error |
| dir_tx | input | 1 | 0 = receive (device to host), 1 = transmit (host to device) |
| pkt_len | input | 5 | Packet length in long words, clamped to 1..DEPTH |
| h_wr_en | input | 1 | Host long-word write strobe (transmit mode) |
| h_wr_data | input | 32 | Host write data |
| h_rd_en | input | 1 | Host long-word read strobe (receive mode) |
| h_rd_data | output | 32 | Oldest long word in the FIFO |
| d_in_valid | input | 1 | Device halfword valid (receive mode) |
| d_in_ready | output | 1 | Block accepts a device halfword |
| d_in_data | input | 16 | Device halfword in |
| d_out_valid | output | 1 | Halfword available for the device (transmit mode) |
| d_out_ready | input | 1 | Device takes the halfword |
| d_out_data | output | 16 | Device halfword out |
| rx_alarm | output | 1 | At least one packet is waiting for the host |
| tx_alarm | output | 1 | Room for at least one packet from the host |
| xfer_err | output | 1 | Sticky overflow/underflow flag |

## Verification
The assertions assume that dir_tx changes only in a cycle where flush is high, so a direction switch never leaves stale data or a pending halfword across the switch. They also assume that the device sink holds d_out_ready steady between the edges it means to use. The stimulus changes direction and packet length only inside one mode-setting step that also raises flush. It drives every input half a period away from the rising edge. Host strobes are raised only in the direction they serve, except for the deliberate overflow and underflow probes.

// File: rtl/pkt_alarm_pkg.sv
package pkt_alarm_pkg;
  localparam int unsigned HOST_W = 32;
  localparam int unsigned DEV_W  = 16;

  typedef enum logic {
    MODE_RX = 1'b0,
    MODE_TX = 1'b1
  } xfer_mode_e;
endpackage

// File: rtl/pkt_fifo_mem.sv
module pkt_fifo_mem #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              pop,
  output logic [WORD_W-1:0] head,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic              empty
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic              do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/pkt_rx_packer.sv
module pkt_rx_packer #(
  parameter int unsigned HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                enable,
  input  logic                in_valid,
  input  logic [HALF_W-1:0]   in_data,
  output logic                in_ready,
  input  logic                fifo_full,
  output logic                push,
  output logic [2*HALF_W-1:0] push_data
);
  logic              half_held;
  logic [HALF_W-1:0] low_q;
  logic              beat;

  assign in_ready  = enable && (!half_held || !fifo_full);
  assign beat      = in_valid && in_ready;
  assign push      = beat && half_held;
  assign push_data = {in_data, low_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_held <= 1'b0;
      low_q     <= '0;
    end else if (flush) begin
      half_held <= 1'b0;
    end else if (beat) begin
      if (!half_held) low_q <= in_data;
      half_held <= !half_held;
    end
  end
endmodule

// File: rtl/pkt_tx_unpacker.sv
module pkt_tx_unpacker #(
  parameter int unsigned HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                enable,
  input  logic [2*HALF_W-1:0] head,
  input  logic                fifo_empty,
  output logic                pop,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [HALF_W-1:0]   out_data
);
  logic              high_pend;
  logic [HALF_W-1:0] high_q;
  logic              beat;

  assign out_valid = enable && (high_pend || !fifo_empty);
  assign beat      = out_valid && out_ready;
  assign pop       = beat && !high_pend;
  assign out_data  = high_pend ? high_q : head[HALF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_pend <= 1'b0;
      high_q    <= '0;
    end else if (flush) begin
      high_pend <= 1'b0;
    end else if (beat) begin
      if (!high_pend) high_q <= head[2*HALF_W-1:HALF_W];
      high_pend <= !high_pend;
    end
  end
endmodule

// File: rtl/pkt_alarm_gen.sv
module pkt_alarm_gen #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          mode_tx,
  input  logic [CW-1:0] pkt_len,
  input  logic [CW-1:0] count,
  output logic [CW-1:0] eff_len,
  output logic          rx_alarm,
  output logic          tx_alarm
);
  logic [CW-1:0] free_words;

  always_comb begin
    if (pkt_len == '0)                eff_len = CW'(1);
    else if (pkt_len > CW'(DEPTH))    eff_len = CW'(DEPTH);
    else                              eff_len = pkt_len;
  end

  assign free_words = CW'(DEPTH) - count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_alarm <= 1'b0;
      tx_alarm <= 1'b0;
    end else begin
      rx_alarm <= !flush && !mode_tx && (count >= eff_len);
      tx_alarm <= !flush &&  mode_tx && (free_words >= eff_len);
    end
  end
endmodule

// File: rtl/pkt_alarm_fifo.sv
module pkt_alarm_fifo
  import pkt_alarm_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              dir_tx,
  input  logic [CW-1:0]     pkt_len,
  input  logic              h_wr_en,
  input  logic [HOST_W-1:0] h_wr_data,
  input  logic              h_rd_en,
  output logic [HOST_W-1:0] h_rd_data,
  input  logic              d_in_valid,
  output logic              d_in_ready,
  input  logic [DEV_W-1:0]  d_in_data,
  output logic              d_out_valid,
  input  logic              d_out_ready,
  output logic [DEV_W-1:0]  d_out_data,
  output logic              rx_alarm,
  output logic              tx_alarm,
  output logic              xfer_err
);
  xfer_mode_e        mode;
  logic              fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [HOST_W-1:0] fifo_wdata, fifo_head;
  logic [CW-1:0]     fifo_cnt, eff_len;
  logic              pk_push, up_pop;
  logic [HOST_W-1:0] pk_data;
  logic              overflow, underflow;

  assign mode = dir_tx ? MODE_TX : MODE_RX;

  pkt_rx_packer #(.HALF_W(DEV_W)) packer_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .enable(mode == MODE_RX),
    .in_valid(d_in_valid), .in_data(d_in_data), .in_ready(d_in_ready),
    .fifo_full(fifo_full), .push(pk_push), .push_data(pk_data)
  );

  pkt_tx_unpacker #(.HALF_W(DEV_W)) unpacker_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .enable(mode == MODE_TX),
    .head(fifo_head), .fifo_empty(fifo_empty), .pop(up_pop),
    .out_valid(d_out_valid), .out_ready(d_out_ready), .out_data(d_out_data)
  );

  always_comb begin
    if (mode == MODE_TX) begin
      fifo_push  = h_wr_en;
      fifo_wdata = h_wr_data;
      fifo_pop   = up_pop;
    end else begin
      fifo_push  = pk_push;
      fifo_wdata = pk_data;
      fifo_pop   = h_rd_en;
    end
  end

  pkt_fifo_mem #(.WORD_W(HOST_W), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(fifo_push), .push_data(fifo_wdata), .pop(fifo_pop),
    .head(fifo_head), .count(fifo_cnt), .full(fifo_full), .empty(fifo_empty)
  );

  assign h_rd_data = fifo_head;

  pkt_alarm_gen #(.DEPTH(DEPTH)) alarm_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .mode_tx(mode == MODE_TX), .pkt_len(pkt_len), .count(fifo_cnt),
    .eff_len(eff_len), .rx_alarm(rx_alarm), .tx_alarm(tx_alarm)
  );

  assign overflow  = (mode == MODE_TX) && h_wr_en && fifo_full;
  assign underflow = (mode == MODE_RX) && h_rd_en && fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     xfer_err <= 1'b0;
    else if (flush)                 xfer_err <= 1'b0;
    else if (overflow || underflow) xfer_err <= 1'b1;
  end
endmodule

// File: rtl/pkt_alarm_fifo_chk.sv
module pkt_alarm_fifo_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          dir_tx,
  input logic          h_wr_en,
  input logic          h_rd_en,
  input logic          d_out_valid,
  input logic          d_out_ready,
  input logic [15:0]   d_out_data,
  input logic          rx_alarm,
  input logic          tx_alarm,
  input logic          xfer_err,
  input logic [CW-1:0] fifo_cnt,
  input logic [CW-1:0] eff_len
);
  // R2
  rx_alarm_basis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_alarm |-> (!$past(dir_tx) && !$past(flush) &&
                  int'($past(fifo_cnt)) >= int'($past(eff_len))));

  // R3
  tx_alarm_basis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_alarm |-> ($past(dir_tx) && !$past(flush) &&
                  int'(DEPTH) - int'($past(fifo_cnt)) >= int'($past(eff_len))));

  // R4
  eff_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(eff_len) >= 1) && (int'(eff_len) <= int'(DEPTH)));

  // R6
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_tx && d_out_valid && !d_out_ready && !flush)
      |=> (flush || (d_out_valid && $stable(d_out_data))));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_cnt) <= int'(DEPTH));

  // R8
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_tx && h_wr_en && int'(fifo_cnt) == int'(DEPTH) && !flush) |=> xfer_err);

  // R9
  underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_tx && h_rd_en && fifo_cnt == '0 && !flush) |=> (xfer_err && fifo_cnt == '0));

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fifo_cnt == '0 && !rx_alarm && !tx_alarm && !xfer_err));
endmodule

bind pkt_alarm_fifo pkt_alarm_fifo_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .dir_tx(dir_tx),
  .h_wr_en(h_wr_en), .h_rd_en(h_rd_en),
  .d_out_valid(d_out_valid), .d_out_ready(d_out_ready), .d_out_data(d_out_data),
  .rx_alarm(rx_alarm), .tx_alarm(tx_alarm), .xfer_err(xfer_err),
  .fifo_cnt(fifo_cnt), .eff_len(eff_len)
);

// File: tb/pkt_alarm_fifo_tb_top.sv
module pkt_alarm_fifo_tb_top;
  localparam int DEPTH = 16;
  localparam int CW    = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          dir_tx = 1'b0;
  logic [CW-1:0] pkt_len = 5'd8;
  logic          h_wr_en = 1'b0;
  logic [31:0]   h_wr_data = '0;
  logic          h_rd_en = 1'b0;
  logic [31:0]   h_rd_data;
  logic          d_in_valid = 1'b0;
  logic          d_in_ready;
  logic [15:0]   d_in_data = '0;
  logic          d_out_valid;
  logic          d_out_ready = 1'b0;
  logic [15:0]   d_out_data;
  logic          rx_alarm, tx_alarm, xfer_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pkt_alarm_fifo #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .dir_tx(dir_tx), .pkt_len(pkt_len),
    .h_wr_en(h_wr_en), .h_wr_data(h_wr_data), .h_rd_en(h_rd_en), .h_rd_data(h_rd_data),
    .d_in_valid(d_in_valid), .d_in_ready(d_in_ready), .d_in_data(d_in_data),
    .d_out_valid(d_out_valid), .d_out_ready(d_out_ready), .d_out_data(d_out_data),
    .rx_alarm(rx_alarm), .tx_alarm(tx_alarm), .xfer_err(xfer_err)
  );

  task automatic check_eq(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int clamp_len(int l);
    if (l == 0) return 1;
    if (l > DEPTH) return DEPTH;
    return l;
  endfunction

  function automatic logic [31:0] pattern(int l, int i);
    return {8'(l), 8'(i), 8'(i * 7 + 3), 8'(l ^ 8'h5A)};
  endfunction

  task automatic set_mode(bit tx, int len);
    @(negedge clk);
    dir_tx  = tx;
    pkt_len = CW'(len);
    flush   = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    check_eq("R10", "rx_alarm after flush", rx_alarm, 0);
    check_eq("R10", "tx_alarm after flush", tx_alarm, 0);
    check_eq("R10", "xfer_err after flush", xfer_err, 0);
  endtask

  task automatic host_write(logic [31:0] w);
    @(negedge clk);
    h_wr_en = 1'b1;
    h_wr_data = w;
    @(negedge clk);
    h_wr_en = 1'b0;
  endtask

  task automatic dev_push(logic [15:0] hw);
    @(negedge clk);
    d_in_valid = 1'b1;
    d_in_data  = hw;
    @(negedge clk);
    d_in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_eq("R1", "rx_alarm", rx_alarm, 0);
    check_eq("R1", "tx_alarm", tx_alarm, 0);
    check_eq("R1", "xfer_err", xfer_err, 0);
    check_eq("R1", "d_out_valid", d_out_valid, 0);
    check_eq("R1", "d_in_ready", d_in_ready, 1);

    // Transmit sweep: R3, R4, R6, R8, R11
    for (int len = 0; len <= 24; len++) begin
      int c;
      c = clamp_len(len);
      set_mode(1'b1, len);
      @(negedge clk);
      check_eq("R3", "tx_alarm empty", tx_alarm, 1);
      for (int n = 1; n <= DEPTH; n++) begin
        host_write(pattern(len, n));
        @(negedge clk);
        check_eq("R3_R4", "tx_alarm vs free space", tx_alarm, ((DEPTH - n) >= c) ? 1 : 0);
        check_eq("R2", "rx_alarm in tx mode", rx_alarm, 0);
      end
      host_write(32'hDEAD_0BAD);
      check_eq("R8", "xfer_err after overflow", xfer_err, 1);
      d_out_ready = 1'b1;
      for (int i = 1; i <= DEPTH; i++) begin
        logic [31:0] w;
        w = pattern(len, i);
        check_eq("R6_R11", "low half valid", d_out_valid, 1);
        check_eq("R6_R11", "low half data", d_out_data, w[15:0]);
        @(negedge clk);
        check_eq("R6_R11", "high half data", d_out_data, w[31:16]);
        @(negedge clk);
      end
      check_eq("R8", "dropped word absent", d_out_valid, 0);
      d_out_ready = 1'b0;
    end

    // Receive sweep: R2, R4, R5, R7, R9, R10, R11
    for (int len = 0; len <= 24; len++) begin
      int c;
      c = clamp_len(len);
      set_mode(1'b0, len);
      @(negedge clk);
      check_eq("R2", "rx_alarm empty", rx_alarm, 0);
      for (int n = 1; n <= DEPTH; n++) begin
        logic [31:0] w;
        w = pattern(len, n);
        dev_push(w[15:0]);
        dev_push(w[31:16]);
        @(negedge clk);
        check_eq("R2_R4", "rx_alarm vs occupancy", rx_alarm, (n >= c) ? 1 : 0);
        check_eq("R3", "tx_alarm in rx mode", tx_alarm, 0);
      end
      check_eq("R7", "ready when full, nothing held", d_in_ready, 1);
      dev_push(16'h7777);
      check_eq("R7", "ready when full, half held", d_in_ready, 0);
      for (int i = 1; i <= DEPTH; i++) begin
        check_eq("R5_R11", "host read word", h_rd_data, pattern(len, i));
        h_rd_en = 1'b1;
        @(negedge clk);
      end
      h_rd_en = 1'b0;
      check_eq("R7", "ready after drain", d_in_ready, 1);
      check_eq("R9", "no error before underflow", xfer_err, 0);
      h_rd_en = 1'b1;
      @(negedge clk);
      h_rd_en = 1'b0;
      check_eq("R9", "xfer_err after underflow", xfer_err, 1);
      @(negedge clk);
      check_eq("R9", "rx_alarm after underflow", rx_alarm, 0);
      // held halfword 7777 must be discarded by flush
      set_mode(1'b0, 1);
      dev_push(16'h1357);
      dev_push(16'h2468);
      @(negedge clk);
      check_eq("R10", "rx_alarm fresh word", rx_alarm, 1);
      check_eq("R10", "partial word discarded", h_rd_data, 32'h2468_1357);
    end

    // Back-pressure on the device output: R6
    set_mode(1'b1, 8);
    host_write(32'hBEEF_1234);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_eq("R6", "held valid", d_out_valid, 1);
      check_eq("R6", "held low data", d_out_data, 16'h1234);
    end
    d_out_ready = 1'b1;
    @(negedge clk);
    d_out_ready = 1'b0;
    check_eq("R6", "high half after low taken", d_out_data, 16'hBEEF);
    @(negedge clk);
    check_eq("R6", "high half held valid", d_out_valid, 1);
    check_eq("R6", "high half held data", d_out_data, 16'hBEEF);
    d_out_ready = 1'b1;
    @(negedge clk);
    d_out_ready = 1'b0;
    check_eq("R6", "valid drops when drained", d_out_valid, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule